// File: doc/BRIEF.md
# Serial Write Receiver for Display Commands and Pixel Data

This block takes bytes from a microprocessor over a two-wire serial link, a serial clock and a serial data line. It delivers each complete byte to the system clock domain. Bits are framed only by the chip-select pair and a bit counter. There are no start or stop bits. The first bit shifted in becomes the most significant bit of the byte. After eight rising serial-clock edges, the assembled byte is published on the system side as a single-cycle strobe. The byte carries a type flag that says whether it is pixel data or a control byte.

The link only writes; nothing can be read back over it. While the chip is deselected, the bit counter and the partial byte are held cleared. This lets the host resynchronise at any time by toggling chip select. Inside one selection, bytes may follow each other with no gap, because the counter wraps after the eighth bit.

Top module: `serial_wr_rx`

## Requirements
- R1: While `rst_n` is low and at the first sample after it rises, `rx_valid` is 0, `rx_byte` is 0x00 and `rx_is_pixel` is 0.
- R2: The receiver accepts bits only while `cs_a_n` is 0 and `cs_b` is 1. Serial-clock edges in any other chip-select state produce no byte and do not advance the bit count.
- R3: Leaving the selected state discards any partial byte. After reselection, the next eight bits form a fresh byte.
- R4: `sdi` is sampled on each rising edge of `sclk`. The first bit of a byte lands in bit 7 of `rx_byte` and the eighth in bit 0.
- R5: Each completed byte raises `rx_valid` for exactly one `clk` cycle. `rx_byte` and `rx_is_pixel` change only in a cycle where `rx_valid` is 1.
- R6: `rs` is sampled with the eighth bit only. `rs`=1 gives `rx_is_pixel`=1 (pixel data) and `rs`=0 gives `rx_is_pixel`=0 (control byte).
- R7: Within one selection, the bit count wraps after the eighth bit, so consecutive bytes are received without deselecting.
- R8: When the eighth `sclk` rising edge falls between two `clk` edges, `rx_valid` is 1 in the cycle after the third `clk` rising edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data, sampled on the rising `sclk` edge |
| rs | input | 1 | Byte type: 1 for pixel data, 0 for control |
| rx_valid | output | 1 | One-cycle strobe marking a new byte |
| rx_byte | output | 8 | Last received byte |
| rx_is_pixel | output | 1 | Type flag of the last received byte |

## Verification
The assertions assume that completed bytes are separated by more than four system clock cycles. This keeps each toggle seen by the synchroniser as one pulse, and keeps the held byte stable while it is captured. They also assume that chip select changes only while `sclk` is low. The stimulus drives every input a fixed offset after a `clk` edge and holds each `sclk` phase for two `clk` cycles, so one byte spans 32 cycles. It then mixes partial bytes, both deselect conditions, a mid-byte change of `rs`, and back-to-back bytes against a behavioural model.

// File: rtl/serial_wr_rx.sv
module serial_wr_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_a_n,
  input  logic         cs_b,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         rs,
  output logic         rx_valid,
  output logic [W-1:0] rx_byte,
  output logic         rx_is_pixel
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          sel, clr;
  logic [W-2:0]  shreg;
  logic [CW-1:0] cnt;
  logic [W-1:0]  hold_byte;
  logic          hold_rs, tog;
  logic          tog_s1, tog_s2, tog_s3;

  assign sel = ~cs_a_n & cs_b;
  assign clr = ~rst_n | ~sel;

  always_ff @(posedge sclk or posedge clr) begin
    if (clr) begin
      shreg <= '0;
      cnt   <= '0;
    end else begin
      shreg <= {shreg[W-3:0], sdi};
      cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_byte <= '0;
      hold_rs   <= 1'b0;
      tog       <= 1'b0;
    end else if (sel && cnt == LAST) begin
      hold_byte <= {shreg, sdi};
      hold_rs   <= rs;
      tog       <= ~tog;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {tog_s1, tog_s2, tog_s3} <= '0;
      rx_valid    <= 1'b0;
      rx_byte     <= '0;
      rx_is_pixel <= 1'b0;
    end else begin
      {tog_s1, tog_s2, tog_s3} <= {tog, tog_s1, tog_s2};
      rx_valid <= tog_s2 ^ tog_s3;
      if (tog_s2 ^ tog_s3) begin
        rx_byte     <= hold_byte;
        rx_is_pixel <= hold_rs;
      end
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R5
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> rx_valid);
  // R6
  type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_is_pixel) |-> rx_valid);
  // R7
  count_wrap_chk: assert property (@(posedge sclk) disable iff (clr)
    (cnt == LAST) |=> (cnt == '0));
  // R2
  tog_only_last_chk: assert property (@(posedge sclk) disable iff (clr)
    (cnt != LAST) |=> $stable(tog));
endmodule

// File: tb/serial_wr_rx_tb.sv
module serial_wr_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_a_n = 1'b1, cs_b = 1'b0, sclk = 1'b0, sdi = 1'b0, rs = 1'b0;
  logic       rx_valid, rx_is_pixel;
  logic [7:0] rx_byte;

  serial_wr_rx u_dut (.clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .sclk(sclk), .sdi(sdi), .rs(rs), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_is_pixel(rx_is_pixel));

  always #4 clk = ~clk;

  int errors = 0, checks = 0, ncyc = 0;
  int m_cnt = 0, m_acc = 0;
  int due_q[$];
  int val_q[$];
  bit run_chk = 0;
  string cur_req = "R1";

  always @(posedge clk) ncyc <= ncyc + 1;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic sel(input logic a_n, input logic b);
    cs_a_n = a_n; cs_b = b;
    if (!(a_n == 1'b0 && b == 1'b1)) begin m_cnt = 0; m_acc = 0; end
    tick(2);
  endtask

  task automatic send_bit(input logic b, input logic r);
    sdi = b; rs = r;
    tick(2);
    sclk = 1'b1;
    if (cs_a_n == 1'b0 && cs_b == 1'b1) begin
      m_acc = ((m_acc << 1) | int'(b)) & 255;
      m_cnt++;
      if (m_cnt == 8) begin
        due_q.push_back(ncyc + 3);
        val_q.push_back(m_acc | (int'(r) << 8));
        m_cnt = 0; m_acc = 0;
      end
    end
    tick(2);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic r);
    for (int i = 7; i >= 0; i--) send_bit(d[i], r);
  endtask

  always @(negedge clk) if (run_chk) begin
    automatic bit exp = (due_q.size() > 0) && (due_q[0] == ncyc);
    checks++;
    if (rx_valid !== exp) begin
      errors++;
      $display("FAIL %s R5 R8 rx_valid got %0b exp %0b at cycle %0d", cur_req, rx_valid, exp, ncyc);
    end
    if (exp) begin
      automatic int v = val_q[0];
      checks++;
      if (rx_byte !== v[7:0] || rx_is_pixel !== v[8]) begin
        errors++;
        $display("FAIL %s R4 R6 byte/type got %02h/%0b exp %02h/%0b", cur_req,
                 rx_byte, rx_is_pixel, v[7:0], v[8]);
      end
      void'(due_q.pop_front());
      void'(val_q.pop_front());
    end
  end

  initial begin
    fork
      begin
        tick(3);
        checks++;
        if (rx_valid !== 1'b0 || rx_byte !== 8'h00 || rx_is_pixel !== 1'b0) begin
          errors++;
          $display("FAIL R1 reset outputs got %0b/%02h/%0b exp 0/00/0", rx_valid, rx_byte, rx_is_pixel);
        end
        rst_n = 1'b1;
        tick(1);
        checks++;
        if (rx_valid !== 1'b0 || rx_byte !== 8'h00 || rx_is_pixel !== 1'b0) begin
          errors++;
          $display("FAIL R1 after reset got %0b/%02h/%0b exp 0/00/0", rx_valid, rx_byte, rx_is_pixel);
        end
        run_chk = 1;
        cur_req = "R4"; sel(1'b0, 1'b1);
        send_byte(8'hA5, 1'b1); tick(6);
        cur_req = "R6"; send_byte(8'h3C, 1'b0); tick(6);
        cur_req = "R7"; send_byte(8'hFF, 1'b1); send_byte(8'h00, 1'b0); send_byte(8'h81, 1'b1); tick(6);
        cur_req = "R3"; send_bit(1, 0); send_bit(1, 0); send_bit(0, 0);
        sel(1'b1, 1'b1); sel(1'b0, 1'b1);
        send_byte(8'h5A, 1'b0); tick(6);
        cur_req = "R2"; sel(1'b1, 1'b1); send_byte(8'hC3, 1'b1); tick(6);
        sel(1'b0, 1'b0); send_byte(8'h96, 1'b1); tick(6);
        sel(1'b0, 1'b1); send_byte(8'h12, 1'b1); tick(6);
        cur_req = "R6"; for (int i = 7; i >= 1; i--) send_bit(i[0], 1'b0);
        send_bit(1'b1, 1'b1); tick(6);
        for (int i = 7; i >= 1; i--) send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b0); tick(6);
        cur_req = "R8"; send_byte(8'h7E, 1'b1); tick(8);
        checks++;
        if (due_q.size() != 0) begin
          errors++;
          $display("FAIL R5 pending bytes got %0d exp 0", due_q.size());
        end
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    run_chk = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule